// File: doc/BRIEF.md
# Gray-Pointer Command Cache Puller

This block empties a command cache whose read and write positions are kept in Gray code. The cache storage is outside the block. The block shows the storage which slot to read, and the storage returns that slot's subchannel, method and 32-bit data word on the same cycle. The block compares its own get pointer with the put pointer driven by the producer. Whenever the two differ and pulling is enabled, it reads the slot at the head of the cache and works out what kind of entry it is.

A method of zero marks the data word as an object name. For such an entry the block raises a request to an external lookup engine. Any other method is a command, and the block hands it to the graphics engine together with the current channel. The channel comes from a separate input, not from the entry.

The get pointer moves only after the downstream side acknowledges the entry. To move it, the block converts the pointer from Gray code to binary, adds one, masks the result to the cache size and converts it back to Gray code. If the lookup reports a failure, the block turns off its own enable and keeps the entry at the head. The entry is retried after pulling is enabled again.

Top module: `cmd_puller`

## Requirements
- R1: After reset, `get_addr` is zero, `pull_en` is low, and neither `lk_req` nor `eng_req` is asserted.
- R2: When `put_addr` equals `get_addr`, no new request is raised.
- R3: While `pull_en` is low, no new request is raised, even if the cache holds entries.
- R4: Pointers are byte addresses of 32-bit slots. Bits [1:0] of `get_addr` are always zero, and `rd_idx` equals `get_addr` shifted right by two, which is the Gray-coded slot index.
- R5: An entry with method value 0 raises `lk_req` one cycle after it is seen. While `lk_req` is high, `cmd_data` carries the name, `cmd_subch` carries the entry's subchannel and `cmd_chan` carries the value that `chan_id` had when the entry was taken.
- R6: An entry with a non-zero method raises `eng_req` one cycle after it is seen. While `eng_req` is high, `cmd_method`, `cmd_subch`, `cmd_data` and `cmd_chan` carry the entry's fields and the captured channel.
- R7: A request stays high, with all `cmd_*` outputs stable, until its acknowledge arrives. `lk_req` and `eng_req` are never high together, and both drop in the cycle after the acknowledge.
- R8: An acknowledge that is not a failure moves the slot index to gray(bin+1 mod DEPTH), so exactly one index bit changes and the index wraps after DEPTH entries. `get_addr` changes at no other time.
- R9: A lookup acknowledge with `lk_fail` high clears `pull_en` and leaves `get_addr` unchanged. No request follows until `pull_en_set` is pulsed again, and then the same entry is offered again.
- R10: A pulse on `pull_en_set` sets `pull_en` on the next cycle. If it coincides with a failing lookup acknowledge, the failure wins and `pull_en` is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pull_en_set | input | 1 | Pulse that enables pulling |
| chan_id | input | CHAN_W | Current channel, taken with each entry |
| put_addr | input | ADDR_W | Producer write pointer, Gray index shifted left by 2 |
| get_addr | output | ADDR_W | Puller read pointer, Gray index shifted left by 2 |
| rd_idx | output | IDX_W | Gray-coded slot index to read from the storage |
| ent_subch | input | SUBCH_W | Subchannel of the addressed slot |
| ent_method | input | METHOD_W | Method of the addressed slot |
| ent_data | input | DATA_W | Data word of the addressed slot |
| lk_req | output | 1 | Object lookup request |
| lk_ack | input | 1 | Lookup done |
| lk_fail | input | 1 | Lookup failed, valid with `lk_ack` |
| eng_req | output | 1 | Engine dispatch request |
| eng_ack | input | 1 | Engine accepted the command |
| cmd_chan | output | CHAN_W | Channel of the pending entry |
| cmd_subch | output | SUBCH_W | Subchannel of the pending entry |
| cmd_method | output | METHOD_W | Method of the pending entry |
| cmd_data | output | DATA_W | Data word or object name of the pending entry |
| pull_en | output | 1 | Puller enable bit |

## Verification
The bench builds the block with DEPTH set to 8, so the 3-bit Gray index wraps after only eight drained entries. The stimulus table has ten rows, which carries the pointer through the whole Gray cycle and past the wrap point. The other widths stay at their defaults: the lookup name is a full 32-bit word and the channel and subchannel fields can carry their top values. Together these cover both kinds of dispatch, acknowledges that are held off for several cycles, and a failed lookup followed by a retry near the point where the index wraps.

// File: rtl/cmd_puller_pkg.sv
// Shared types for the command cache puller.
// Assumes: used by cmd_puller and its submodules only.
package cmd_puller_pkg;
    typedef enum logic [1:0] {
        PS_IDLE   = 2'd0,
        PS_LOOKUP = 2'd1,
        PS_ENGINE = 2'd2
    } pull_state_t;

    typedef enum logic {
        KIND_ENGINE = 1'b0,
        KIND_NAME   = 1'b1
    } entry_kind_t;
endpackage

// File: rtl/puller_gray_step.sv
// Computes the Gray-coded successor of a Gray-coded slot index.
// The index is converted to binary, incremented, masked to DEPTH-1
// and converted back to Gray code.
// Assumes: DEPTH is a power of two and equals 2**IDX_W.
module puller_gray_step #(
    parameter int DEPTH = 32,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic [IDX_W-1:0] gray_cur,
    output logic [IDX_W-1:0] gray_next
);
    localparam logic [IDX_W-1:0] IDX_MASK = IDX_W'(DEPTH - 1);

    logic [IDX_W-1:0] bin_cur;
    logic [IDX_W-1:0] bin_next;

    // Each binary bit is the XOR of all Gray bits at or above its position.
    for (genvar i = 0; i < IDX_W; i++) begin : g_to_bin
        assign bin_cur[i] = ^gray_cur[IDX_W-1:i];
    end

    // Increment, apply the size mask, then return to Gray code.
    always_comb begin
        bin_next  = (bin_cur + IDX_W'(1)) & IDX_MASK;
        gray_next = bin_next ^ (bin_next >> 1);
    end
endmodule

// File: rtl/puller_entry_class.sv
// Classifies the slot at the head of the cache.
// A zero method marks an object name; any other method is a command
// for the graphics engine.
// Assumes: the entry fields are valid whenever the cache is non-empty.
module puller_entry_class
    import cmd_puller_pkg::*;
#(
    parameter int METHOD_W = 11
) (
    input  logic [METHOD_W-1:0] method,
    output entry_kind_t         kind
);
    // Pick the destination from the method value alone.
    always_comb begin
        kind = (method == '0) ? KIND_NAME : KIND_ENGINE;
    end
endmodule

// File: rtl/puller_ctrl.sv
// Sequencer for the puller: takes one entry, holds one request until
// it is acknowledged, then tells the datapath to advance or to stop.
// Assumes: acknowledges are only meaningful while the matching request
// is high. Acknowledges at other times are ignored.
module puller_ctrl
    import cmd_puller_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        pull_en,
    input  logic        not_empty,
    input  entry_kind_t kind,
    input  logic        lk_ack,
    input  logic        lk_fail,
    input  logic        eng_ack,
    output logic        take,
    output logic        advance,
    output logic        fail_stop,
    output logic        lk_req,
    output logic        eng_req
);
    pull_state_t state_q;
    pull_state_t state_d;

    // Next-state logic and the single-cycle strobes for the datapath.
    always_comb begin
        state_d   = state_q;
        take      = 1'b0;
        advance   = 1'b0;
        fail_stop = 1'b0;
        unique case (state_q)
            PS_IDLE: begin
                if (pull_en && not_empty) begin
                    take    = 1'b1;
                    state_d = (kind == KIND_NAME) ? PS_LOOKUP : PS_ENGINE;
                end
            end
            PS_LOOKUP: begin
                if (lk_ack) begin
                    fail_stop = lk_fail;
                    advance   = !lk_fail;
                    state_d   = PS_IDLE;
                end
            end
            PS_ENGINE: begin
                if (eng_ack) begin
                    advance = 1'b1;
                    state_d = PS_IDLE;
                end
            end
            default: state_d = PS_IDLE;
        endcase
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PS_IDLE;
        else        state_q <= state_d;
    end

    // The requests come straight from the registered state, so they are glitch-free.
    always_comb begin
        lk_req  = (state_q == PS_LOOKUP);
        eng_req = (state_q == PS_ENGINE);
    end
endmodule

// File: rtl/cmd_puller.sv
// Command cache puller. It compares the Gray-coded put and get
// pointers, reads the head slot, sends object names to the lookup
// engine and commands to the graphics engine, and advances the get
// pointer in Gray code once the entry is acknowledged.
// Assumes: the storage returns the slot at rd_idx in the same cycle,
// put_addr is synchronous to clk, and DEPTH is a power of two.
module cmd_puller
    import cmd_puller_pkg::*;
#(
    parameter int DEPTH    = 32,
    parameter int CHAN_W   = 7,
    parameter int SUBCH_W  = 3,
    parameter int METHOD_W = 11,
    parameter int DATA_W   = 32,
    parameter int IDX_W    = $clog2(DEPTH),
    parameter int ADDR_W   = IDX_W + 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pull_en_set,
    input  logic [CHAN_W-1:0]   chan_id,
    input  logic [ADDR_W-1:0]   put_addr,
    output logic [ADDR_W-1:0]   get_addr,
    output logic [IDX_W-1:0]    rd_idx,
    input  logic [SUBCH_W-1:0]  ent_subch,
    input  logic [METHOD_W-1:0] ent_method,
    input  logic [DATA_W-1:0]   ent_data,
    output logic                lk_req,
    input  logic                lk_ack,
    input  logic                lk_fail,
    output logic                eng_req,
    input  logic                eng_ack,
    output logic [CHAN_W-1:0]   cmd_chan,
    output logic [SUBCH_W-1:0]  cmd_subch,
    output logic [METHOD_W-1:0] cmd_method,
    output logic [DATA_W-1:0]   cmd_data,
    output logic                pull_en
);
    logic [IDX_W-1:0] get_gray_q;
    logic [IDX_W-1:0] get_gray_next;
    logic             not_empty;
    logic             take;
    logic             advance;
    logic             fail_stop;
    entry_kind_t      kind;

    // Expose the pointer as a byte address and the slot index as its Gray index.
    always_comb begin
        get_addr  = {get_gray_q, 2'b00};
        rd_idx    = get_addr[ADDR_W-1:2];
        not_empty = (put_addr != get_addr);
    end

    puller_entry_class #(
        .METHOD_W (METHOD_W)
    ) u_class (
        .method (ent_method),
        .kind   (kind)
    );

    puller_gray_step #(
        .DEPTH (DEPTH),
        .IDX_W (IDX_W)
    ) u_step (
        .gray_cur  (get_gray_q),
        .gray_next (get_gray_next)
    );

    puller_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .pull_en   (pull_en),
        .not_empty (not_empty),
        .kind      (kind),
        .lk_ack    (lk_ack),
        .lk_fail   (lk_fail),
        .eng_ack   (eng_ack),
        .take      (take),
        .advance   (advance),
        .fail_stop (fail_stop),
        .lk_req    (lk_req),
        .eng_req   (eng_req)
    );

    // Get pointer: moves to the Gray successor only on a successful acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)       get_gray_q <= '0;
        else if (advance) get_gray_q <= get_gray_next;
    end

    // Enable bit: a failed lookup clears it, and this takes priority over the set pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)           pull_en <= 1'b0;
        else if (fail_stop)   pull_en <= 1'b0;
        else if (pull_en_set) pull_en <= 1'b1;
    end

    // Command holding registers: loaded when an entry is taken, held through the handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_chan   <= '0;
            cmd_subch  <= '0;
            cmd_method <= '0;
            cmd_data   <= '0;
        end else if (take) begin
            cmd_chan   <= chan_id;
            cmd_subch  <= ent_subch;
            cmd_method <= ent_method;
            cmd_data   <= ent_data;
        end
    end
endmodule

// File: rtl/cmd_puller_chk.sv
// Property checker for cmd_puller, attached through bind.
// Assumes: the same parameter values as the instance it is bound to.
module cmd_puller_chk #(
    parameter int CHAN_W   = 7,
    parameter int SUBCH_W  = 3,
    parameter int METHOD_W = 11,
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 7
) (
    input logic                clk,
    input logic                rst_n,
    input logic [ADDR_W-1:0]   put_addr,
    input logic [ADDR_W-1:0]   get_addr,
    input logic                pull_en,
    input logic                pull_en_set,
    input logic                lk_req,
    input logic                lk_ack,
    input logic                lk_fail,
    input logic                eng_req,
    input logic                eng_ack,
    input logic [CHAN_W-1:0]   cmd_chan,
    input logic [SUBCH_W-1:0]  cmd_subch,
    input logic [METHOD_W-1:0] cmd_method,
    input logic [DATA_W-1:0]   cmd_data
);
    logic ok_ack;
    assign ok_ack = (eng_req && eng_ack) || (lk_req && lk_ack && !lk_fail);

    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (get_addr == '0) && !pull_en && !lk_req && !eng_req);

    assert_empty_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (put_addr == get_addr) && !lk_req && !eng_req |=> !lk_req && !eng_req);

    assert_disabled_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !pull_en && !lk_req && !eng_req |=> !lk_req && !eng_req);

    assert_aligned_R4: assert property (@(posedge clk) disable iff (!rst_n)
        get_addr[1:0] == 2'b00);

    assert_lookup_method_R5: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |-> cmd_method == '0);

    assert_engine_method_R6: assert property (@(posedge clk) disable iff (!rst_n)
        eng_req |-> cmd_method != '0);

    assert_one_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(lk_req && eng_req));

    assert_hold_lk_R7: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req && !lk_ack |=> lk_req && $stable(cmd_data) && $stable(cmd_chan) && $stable(cmd_subch));

    assert_hold_eng_R7: assert property (@(posedge clk) disable iff (!rst_n)
        eng_req && !eng_ack |=> eng_req && $stable(cmd_data) && $stable(cmd_method)
                                && $stable(cmd_chan) && $stable(cmd_subch));

    assert_drop_after_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_req && lk_ack) || (eng_req && eng_ack) |=> !lk_req && !eng_req);

    assert_ptr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !ok_ack |=> $stable(get_addr));

    assert_gray_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ok_ack |=> $countones(get_addr ^ $past(get_addr)) == 1);

    assert_fail_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req && lk_ack && lk_fail |=> !pull_en && $stable(get_addr));

    assert_enable_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pull_en_set && !(lk_req && lk_ack && lk_fail) |=> pull_en);
endmodule

bind cmd_puller cmd_puller_chk #(
    .CHAN_W   (CHAN_W),
    .SUBCH_W  (SUBCH_W),
    .METHOD_W (METHOD_W),
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .put_addr    (put_addr),
    .get_addr    (get_addr),
    .pull_en     (pull_en),
    .pull_en_set (pull_en_set),
    .lk_req      (lk_req),
    .lk_ack      (lk_ack),
    .lk_fail     (lk_fail),
    .eng_req     (eng_req),
    .eng_ack     (eng_ack),
    .cmd_chan    (cmd_chan),
    .cmd_subch   (cmd_subch),
    .cmd_method  (cmd_method),
    .cmd_data    (cmd_data)
);

// File: tb/tb_cmd_puller.sv
// Self-checking bench for cmd_puller, built with DEPTH = 8.
module tb_cmd_puller;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 8;
    localparam int IDX_W      = 3;
    localparam int ADDR_W     = 5;
    localparam int NVEC       = 10;

    typedef struct packed {
        logic [2:0]  hold;
        logic [6:0]  chan;
        logic [2:0]  subch;
        logic [10:0] method;
        logic [31:0] data;
    } vec_t;

    localparam vec_t VEC [NVEC] = '{
        '{3'd0, 7'h01, 3'd0, 11'h000, 32'hDEAD_BEEF},
        '{3'd0, 7'h01, 3'd2, 11'h104, 32'h0000_0011},
        '{3'd2, 7'h7F, 3'd7, 11'h7FC, 32'hFFFF_FFFF},
        '{3'd0, 7'h10, 3'd1, 11'h000, 32'h1234_5678},
        '{3'd3, 7'h22, 3'd3, 11'h300, 32'h0000_0000},
        '{3'd0, 7'h00, 3'd4, 11'h004, 32'hA5A5_5A5A},
        '{3'd1, 7'h05, 3'd5, 11'h000, 32'h8000_0001},
        '{3'd0, 7'h33, 3'd6, 11'h200, 32'h0F0F_F0F0},
        '{3'd0, 7'h44, 3'd7, 11'h000, 32'hCAFE_0001},
        '{3'd1, 7'h55, 3'd1, 11'h010, 32'h7654_3210}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              pull_en_set = 1'b0;
    logic [6:0]        chan_id = '0;
    logic [ADDR_W-1:0] put_addr = '0;
    logic [ADDR_W-1:0] get_addr;
    logic [IDX_W-1:0]  rd_idx;
    logic [2:0]        ent_subch;
    logic [10:0]       ent_method;
    logic [31:0]       ent_data;
    logic              lk_req, eng_req;
    logic              lk_ack = 1'b0, lk_fail = 1'b0, eng_ack = 1'b0;
    logic [6:0]        cmd_chan;
    logic [2:0]        cmd_subch;
    logic [10:0]       cmd_method;
    logic [31:0]       cmd_data;
    logic              pull_en;

    logic [2:0]  mem_subch  [DEPTH];
    logic [10:0] mem_method [DEPTH];
    logic [31:0] mem_data   [DEPTH];

    int checks = 0;
    int errors = 0;
    int put_bin = 0;
    int get_bin = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign ent_subch  = mem_subch[rd_idx];
    assign ent_method = mem_method[rd_idx];
    assign ent_data   = mem_data[rd_idx];

    cmd_puller #(.DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .pull_en_set(pull_en_set), .chan_id(chan_id),
        .put_addr(put_addr), .get_addr(get_addr), .rd_idx(rd_idx),
        .ent_subch(ent_subch), .ent_method(ent_method), .ent_data(ent_data),
        .lk_req(lk_req), .lk_ack(lk_ack), .lk_fail(lk_fail),
        .eng_req(eng_req), .eng_ack(eng_ack),
        .cmd_chan(cmd_chan), .cmd_subch(cmd_subch), .cmd_method(cmd_method),
        .cmd_data(cmd_data), .pull_en(pull_en)
    );

    function automatic logic [ADDR_W-1:0] addr_of(int b);
        logic [IDX_W-1:0] bb;
        bb = IDX_W'(b % DEPTH);
        return {bb ^ (bb >> 1), 2'b00};
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push(logic [10:0] m, logic [2:0] s, logic [31:0] d);
        logic [ADDR_W-1:0] a;
        a = addr_of(put_bin);
        mem_method[a[ADDR_W-1:2]] = m;
        mem_subch[a[ADDR_W-1:2]]  = s;
        mem_data[a[ADDR_W-1:2]]   = d;
        put_bin  = put_bin + 1;
        put_addr = addr_of(put_bin);
    endtask

    task automatic idle_for(int n, string req);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check(req, {62'd0, lk_req, eng_req}, 64'd0);
        end
    endtask

    // Wait for a request and check it, then acknowledge it and check the pointer.
    task automatic serve(vec_t v, bit fail);
        int w = 0;
        bit name;
        name = (v.method == 11'd0);
        while (!(lk_req || eng_req) && w < 20) begin
            @(negedge clk);
            w++;
        end
        check(name ? "R5 lookup req" : "R6 engine req", {62'd0, lk_req, eng_req},
              name ? 64'd2 : 64'd1);
        check(name ? "R5 data" : "R6 data", 64'(cmd_data), 64'(v.data));
        check(name ? "R5 chan" : "R6 chan", 64'(cmd_chan), 64'(v.chan));
        check(name ? "R5 subch" : "R6 subch", 64'(cmd_subch), 64'(v.subch));
        if (!name) check("R6 method", 64'(cmd_method), 64'(v.method));
        check("R4 index", 64'(rd_idx), 64'(get_addr >> 2));
        for (int h = 0; h < int'(v.hold); h++) begin
            @(negedge clk);
            check("R7 held", {62'd0, lk_req, eng_req}, name ? 64'd2 : 64'd1);
            check("R7 stable", 64'(cmd_data), 64'(v.data));
            check("R8 no move before ack", 64'(get_addr), 64'(addr_of(get_bin)));
        end
        if (name) begin
            lk_ack  = 1'b1;
            lk_fail = fail;
        end else begin
            eng_ack = 1'b1;
        end
        @(negedge clk);
        lk_ack = 1'b0; lk_fail = 1'b0; eng_ack = 1'b0;
        check("R7 drop", {62'd0, lk_req, eng_req}, 64'd0);
        if (!fail) get_bin = get_bin + 1;
        check(fail ? "R9 ptr kept" : "R8 ptr step", 64'(get_addr), 64'(addr_of(get_bin)));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R7 watchdog actual=hang expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_subch[i] = '0; mem_method[i] = '0; mem_data[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 get", 64'(get_addr), 64'd0);
        check("R1 en", 64'(pull_en), 64'd0);
        check("R1 req", {62'd0, lk_req, eng_req}, 64'd0);

        // R2: an empty cache with pulling enabled raises nothing.
        pull_en_set = 1'b1;
        @(negedge clk);
        pull_en_set = 1'b0;
        check("R10 set", 64'(pull_en), 64'd1);
        idle_for(4, "R2 empty");

        // R3: the puller is disabled by a reset, so a queued entry stays untouched.
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        push(11'h0A0, 3'd1, 32'h5555_AAAA);
        idle_for(5, "R3 disabled");
        check("R3 ptr", 64'(get_addr), 64'd0);
        chan_id = 7'h0C;
        pull_en_set = 1'b1;
        @(negedge clk);
        pull_en_set = 1'b0;
        serve('{3'd0, 7'h0C, 3'd1, 11'h0A0, 32'h5555_AAAA}, 1'b0);

        // Table walk, which carries the index past the wrap at DEPTH.
        for (int k = 0; k < NVEC; k++) begin
            chan_id = VEC[k].chan;
            push(VEC[k].method, VEC[k].subch, VEC[k].data);
            serve(VEC[k], 1'b0);
        end
        check("R8 wrapped", 64'(get_bin), 64'(NVEC + 1));
        idle_for(3, "R2 drained");

        // R9: a failed lookup stops the puller and the entry is kept.
        chan_id = 7'h09;
        push(11'h000, 3'd6, 32'hBAD0_0BAD);
        push(11'h0F0, 3'd2, 32'h0000_0077);
        serve('{3'd0, 7'h09, 3'd6, 11'h000, 32'hBAD0_0BAD}, 1'b1);
        check("R9 en cleared", 64'(pull_en), 64'd0);
        idle_for(4, "R9 stopped");
        pull_en_set = 1'b1;
        @(negedge clk);
        pull_en_set = 1'b0;
        serve('{3'd0, 7'h09, 3'd6, 11'h000, 32'hBAD0_0BAD}, 1'b0);
        serve('{3'd0, 7'h09, 3'd2, 11'h0F0, 32'h0000_0077}, 1'b0);

        // R10: a failure and a set pulse in the same cycle leave pulling disabled.
        push(11'h000, 3'd0, 32'h0000_ABCD);
        while (!lk_req) @(negedge clk);
        lk_ack = 1'b1; lk_fail = 1'b1; pull_en_set = 1'b1;
        @(negedge clk);
        lk_ack = 1'b0; lk_fail = 1'b0; pull_en_set = 1'b0;
        check("R10 fail wins", 64'(pull_en), 64'd0);
        check("R9 ptr kept", 64'(get_addr), 64'(addr_of(get_bin)));
        check("R4 aligned", 64'(get_addr[1:0]), 64'd0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule